// File: doc/BRIEF.md
# Dual-Source Bus Ready Synchronizer

This block combines two transfer-complete indications from separate system buses into a single ready flag for a processor. Each indication is active high and means that a device on that bus has taken or delivered its data. It counts only while its own active-low address enable is asserted. The two qualified indications are ORed together and brought into the processor clock domain.

A run-time mode input sets the synchronizer depth. When the mode input is high, the qualified value is captured once on the rising clock edge and drives the output straight away. When it is low, a second capture on the following falling edge is added, so the output settles half a clock later. This second stage gives extra metastability margin for ready sources that are fully asynchronous. The mode input is registered on the rising edge, so a change takes effect at a clock edge and never partway through a phase. An asynchronous active-low reset, released through a local synchronizer, clears every stage and drives the output low.

Top module: `dual_ready_sync`

## Requirements
- R1: While reset is asserted, and after its release until a qualified ready has been captured, `ready` is low. Asserting reset drives `ready` low without waiting for a clock edge.
- R2: `bus_rdy_a` counts as ready only while `bus_en_a_n` is 0. While `bus_en_a_n` is 1, `bus_rdy_a` has no effect on `ready`.
- R3: `bus_rdy_b` counts as ready only while `bus_en_b_n` is 0. While `bus_en_b_n` is 1, `bus_rdy_b` has no effect on `ready`.
- R4: The qualified ready is (`bus_rdy_a` AND NOT `bus_en_a_n`) OR (`bus_rdy_b` AND NOT `bus_en_b_n`). In both modes, `ready` equals this value as captured at the previous rising edge once the falling edge after that capture has passed.
- R5: With `one_stage` = 1, a qualified value present before a rising edge appears on `ready` right after that edge.
- R6: With `one_stage` = 0, a qualified value present before a rising edge does not appear on `ready` at that edge. It appears right after the next falling edge, and `ready` keeps its older value between the two edges.
- R7: `one_stage` is captured on the rising edge. Changing it between edges leaves `ready` unchanged until the next rising edge, when the new depth applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rdy_a | input | 1 | Transfer-complete indication from bus A, active high |
| bus_en_a_n | input | 1 | Active-low qualifier for bus A ready |
| bus_rdy_b | input | 1 | Transfer-complete indication from bus B, active high |
| bus_en_b_n | input | 1 | Active-low qualifier for bus B ready |
| one_stage | input | 1 | 1: single rising-edge stage, 0: rising plus falling stage |
| ready | output | 1 | Synchronized, merged ready to the processor |

## Verification
The bench sweeps all sixteen combinations of the two ready and two enable inputs in each mode. It checks `ready` both after the rising edge and after the falling edge. A design that swapped an enable polarity, or let a disabled source through, would raise `ready` on a combination where it must stay low. A design with the stage order reversed, or with the mode sense inverted, would show the new value half a cycle early or late. The mode is also switched partway through traffic in both directions. A select that was not registered would move `ready` between edges, and one that took effect a cycle late would show the old depth's value. An asynchronous reset asserted while `ready` is high must drop the output immediately.

// File: rtl/rdy_sync_pkg.sv
package rdy_sync_pkg;

  typedef enum logic {
    DEPTH_DUAL   = 1'b0,
    DEPTH_SINGLE = 1'b1
  } sync_depth_e;

endpackage

// File: rtl/rdy_reset_sync.sv
module rdy_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/rdy_qualify.sv
module rdy_qualify #(
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0] src_rdy,
  input  logic [NUM_SRC-1:0] src_en_n,
  output logic               any_rdy
);

  logic [NUM_SRC-1:0] gated;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign gated[i] = src_rdy[i] & ~src_en_n[i];
  end

  assign any_rdy = |gated;

endmodule

// File: rtl/rdy_sync_stages.sv
module rdy_sync_stages
  import rdy_sync_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        din,
  input  sync_depth_e depth,
  output logic        dout
);

  sync_depth_e depth_q;
  sync_depth_e depth_d;
  logic        rise_q;
  logic        rise_d;
  logic        fall_q;
  logic        fall_d;

  always_comb begin
    depth_d = depth;
    rise_d  = din;
    fall_d  = rise_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= DEPTH_SINGLE;
      rise_q  <= 1'b0;
    end else begin
      depth_q <= depth_d;
      rise_q  <= rise_d;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_q <= 1'b0;
    end else begin
      fall_q <= fall_d;
    end
  end

  assign dout = (depth_q == DEPTH_SINGLE) ? rise_q : fall_q;

  // R5
  single_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((depth_q == DEPTH_SINGLE) && $past(rst_n)) |-> (dout == $past(din)));

  // R6
  dual_latency_chk: assert property (@(negedge clk) disable iff (!rst_n)
    ((depth_q == DEPTH_DUAL) && ($past(depth_q) == DEPTH_DUAL)) |-> (dout == $past(rise_q)));

endmodule

// File: rtl/dual_ready_sync.sv
module dual_ready_sync
  import rdy_sync_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_rdy_a,
  input  logic bus_en_a_n,
  input  logic bus_rdy_b,
  input  logic bus_en_b_n,
  input  logic one_stage,
  output logic ready
);

  localparam int NUM_SRC = 2;

  logic               rst_int_n;
  logic [NUM_SRC-1:0] rdy_vec;
  logic [NUM_SRC-1:0] en_n_vec;
  logic               merged;
  sync_depth_e        depth_sel;

  assign rdy_vec   = {bus_rdy_b, bus_rdy_a};
  assign en_n_vec  = {bus_en_b_n, bus_en_a_n};
  assign depth_sel = one_stage ? DEPTH_SINGLE : DEPTH_DUAL;

  rdy_reset_sync #(
    .STAGES(RST_STAGES)
  ) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_int_n)
  );

  rdy_qualify #(
    .NUM_SRC(NUM_SRC)
  ) u_qual (
    .src_rdy (rdy_vec),
    .src_en_n(en_n_vec),
    .any_rdy (merged)
  );

  rdy_sync_stages u_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .din  (merged),
    .depth(depth_sel),
    .dout (ready)
  );

  // R1
  reset_low_chk: assert property (@(posedge clk) (!rst_int_n) |-> !ready);

  // R2 R3
  disabled_ignored_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (one_stage && $past(one_stage) && $past(rst_int_n) && $past(bus_en_a_n && bus_en_b_n))
      |-> !ready);

endmodule

// File: tb/dual_ready_sync_test.sv
module dual_ready_sync_test;

  logic clk = 1'b0;
  logic rst_n;
  logic bus_rdy_a;
  logic bus_en_a_n;
  logic bus_rdy_b;
  logic bus_en_b_n;
  logic one_stage;
  logic ready;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dual_ready_sync uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rdy_a (bus_rdy_a),
    .bus_en_a_n(bus_en_a_n),
    .bus_rdy_b (bus_rdy_b),
    .bus_en_b_n(bus_en_b_n),
    .one_stage (one_stage),
    .ready     (ready)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: ready=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic qual(input logic [3:0] v);
    return (v[0] & ~v[1]) | (v[2] & ~v[3]);
  endfunction

  task automatic drive(input logic [3:0] v);
    bus_rdy_a  = v[0];
    bus_en_a_n = v[1];
    bus_rdy_b  = v[2];
    bus_en_b_n = v[3];
  endtask

  function automatic string tag_of(input logic [3:0] v, input string base);
    string t;
    t = base;
    if (v[0] && v[1]) t = {t, " R2"};
    if (v[2] && v[3]) t = {t, " R3"};
    return t;
  endfunction

  // Called at falling edge + 5 ns; returns there one cycle later.
  task automatic step(input logic [3:0] v, input logic single, inout logic prev);
    logic e;
    e = qual(v);
    drive(v);
    @(posedge clk); #5;
    if (single) chk(tag_of(v, "R5 after rise"), ready, e);
    else        chk(tag_of(v, "R6 held after rise"), ready, prev);
    @(negedge clk); #5;
    chk(tag_of(v, "R4 after fall"), ready, e);
    prev = e;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: ready=%b expected=done", ready);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic prev;
    rst_n = 1'b0;
    one_stage = 1'b1;
    drive(4'b0101);
    #3;
    chk("R1 in reset", ready, 1'b0);
    repeat (3) @(negedge clk);
    #5;
    chk("R1 reset held", ready, 1'b0);
    rst_n = 1'b1;
    drive(4'b0000);
    repeat (4) @(negedge clk);
    #5;
    chk("R1 after release", ready, 1'b0);
    prev = 1'b0;

    for (int m = 1; m >= 0; m--) begin
      one_stage = m[0];
      step(4'b0000, m[0], prev);
      for (int v = 0; v < 16; v++) begin
        step(v[3:0], m[0], prev);
        step(4'b0000, m[0], prev);
      end
      for (int v = 15; v >= 0; v--) step(v[3:0], m[0], prev);
    end

    // Dual to single with qualified ready rising.
    one_stage = 1'b0;
    step(4'b0000, 1'b0, prev);
    one_stage = 1'b1;
    drive(4'b0001);
    #2;
    chk("R7 no change between edges", ready, 1'b0);
    @(posedge clk); #5;
    chk("R7 single depth at next rise", ready, 1'b1);
    @(negedge clk); #5;
    chk("R7 settled", ready, 1'b1);

    // Single to dual with qualified ready falling.
    one_stage = 1'b0;
    drive(4'b0000);
    #2;
    chk("R7 no change between edges", ready, 1'b1);
    @(posedge clk); #5;
    chk("R7 dual depth holds at rise", ready, 1'b1);
    @(negedge clk); #5;
    chk("R7 dual depth after fall", ready, 1'b0);

    // Asynchronous reset while ready is high.
    one_stage = 1'b1;
    drive(4'b0100);
    @(posedge clk); #5;
    chk("R5 before reset", ready, 1'b1);
    rst_n = 1'b0;
    #1;
    chk("R1 async clear", ready, 1'b0);
    @(posedge clk); #5;
    chk("R1 stays low", ready, 1'b0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule